// File: doc/BRIEF.md
# Push-Button Step and Trace Controller

This block sits between a board's push-buttons and a pipelined processor core. It drives the core's clock enable so that the core either runs freely or advances one clock per button press. On request, it also prints selected pipeline values as readable hexadecimal text on a UART transmit line, so a terminal can show what the core is doing while a person steps through a program.

Five raw buttons go into the block. Each one is synchronised to the system clock and debounced, and only the press edge is used. The mode button switches between halted (single-step) and running. The step button gives one enable cycle while the core is halted. The other three buttons each print a different group of values: the fetch address and the instruction word, the write-back register index and data, or the execute-stage result.

A message is a sequence of fields. Each field is eight upper-case hex digits. Fields are separated by a space, and the line ends with carriage return and line feed. The values are captured when the press is accepted. While a line is still being sent, any press on one of the three print buttons is dropped.

Mode machine states: HALT, where the enable is low; PULSE, where the enable is high for one cycle; RUN, where the enable stays high. Transitions: HALT to RUN on a mode press, HALT to PULSE on a step press, PULSE to HALT always, RUN to HALT on a mode press. Formatter states: FS_IDLE, FS_LOAD and FS_WAIT. Transitions: FS_IDLE to FS_LOAD on an accepted print press, FS_LOAD to FS_WAIT when the character is handed to the transmitter, FS_WAIT to FS_LOAD when the transmitter frees up and characters remain, FS_WAIT to FS_IDLE after the line feed. Transmitter states: TS_IDLE, TS_START, TS_DATA and TS_STOP, taken in that order, with each bit time lasting CLK_HZ/BAUD clocks.

Top module: `dbg_step_ctrl`

## Requirements
- R1: During and right after reset, the block is in HALT, core_ce is 0 and uart_tx is 1.
- R2: A button counts as pressed only after its synchronised level has differed from the debounced level for DB_CYCLES consecutive clocks. A raw pulse of DB_CYCLES-1 clocks has no effect. Holding a button produces only one press.
- R3: A mode press toggles between HALT and RUN. In RUN, core_ce stays 1 on every clock.
- R4: In HALT, a step press makes core_ce 1 for exactly one clock. Counting the first clock edge that samples the raw button high as edge 1, core_ce is 1 in the cycle after edge DB_CYCLES+3. The same latency applies to mode presses. A step press in RUN has no effect.
- R5: A print-fetch press sends the fetch address, a space (0x20), the instruction word, then CR (0x0D) and LF (0x0A). Each word is sent as 8 ASCII hex digits, most significant digit first, using 0-9 and A-F.
- R6: A print-writeback press sends the register index, zero-extended to 32 bits, then a space, then the write-back data, then CR LF, with words formatted as in R5.
- R7: A print-execute press sends the execute-stage result followed by CR LF.
- R8: Each character is sent as 8N1, least significant bit first, with every bit lasting CLK_HZ/BAUD clocks. The line idles at 1.
- R9: A print press that arrives while a line is still being sent is dropped and produces no characters.
- R10: The values sent are those on the inputs in the cycle the press is accepted. Later changes to the inputs do not alter a line already started.
- R11: When several print presses are accepted in the same cycle, fetch wins over write-back, and write-back wins over execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_mode | input | 1 | Raw button: toggle run/halt |
| btn_step | input | 1 | Raw button: one-clock step |
| btn_fetch | input | 1 | Raw button: print address and instruction |
| btn_wback | input | 1 | Raw button: print write-back index and data |
| btn_exec | input | 1 | Raw button: print execute result |
| core_pc | input | DATA_W | Fetch address from the core |
| core_instr | input | DATA_W | Instruction word from the core |
| wb_rd_addr | input | RADDR_W | Write-back register index |
| wb_rd_data | input | DATA_W | Write-back data |
| ex_result | input | DATA_W | Execute-stage result |
| core_ce | output | 1 | Clock enable to the core |
| uart_tx | output | 1 | Serial transmit line |

## Verification
A step press or a mode press is expected to change core_ce exactly DB_CYCLES+3 clocks after the first edge that samples the button high. The reference model schedules these changes by cycle number and compares core_ce on every falling edge. Serial output is checked as text, not cycle by cycle. The bench receiver waits for a start bit, samples each bit half a bit time (CLK_HZ/BAUD/2 clocks) after its edge, checks the start and stop levels, and compares each received character against a queue of expected characters. Expected characters are queued when the press is made, from values the bench holds steady until the start bit appears. Any character that arrives with no expected entry is a failure, and so is any entry still waiting at the end; these two cases cover the dropped and glitched presses.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    typedef enum logic [1:0] {MS_HALT, MS_PULSE, MS_RUN} mode_state_e;
    typedef enum logic [1:0] {FS_IDLE, FS_LOAD, FS_WAIT} fmt_state_e;
    typedef enum logic [1:0] {TS_IDLE, TS_START, TS_DATA, TS_STOP} tx_state_e;

    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'b0, n}) : (8'h37 + {4'b0, n});
    endfunction
endpackage

// File: rtl/dbg_btn_cond.sv
module dbg_btn_cond #(
    parameter int DB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press
);
    localparam int CNT_W = (DB_CYCLES > 2) ? $clog2(DB_CYCLES) : 1;

    logic             sync_a, sync_b;
    logic             level_q, level_d1;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            level_q  <= 1'b0;
            level_d1 <= 1'b0;
            cnt_q    <= '0;
        end else begin
            sync_a   <= raw;
            sync_b   <= sync_a;
            level_d1 <= level_q;
            if (sync_b == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(DB_CYCLES - 1)) begin
                cnt_q   <= '0;
                level_q <= sync_b;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign press = level_q & ~level_d1;
endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
    import dbg_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       tx
);
    localparam int DIV   = CLK_HZ / BAUD;
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [2:0]       bit_q, bit_d;
    logic [7:0]       shift_q, shift_d;
    logic             bit_end;

    assign bit_end = (cnt_q == CNT_W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            shift_q <= shift_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = bit_end ? '0 : cnt_q + 1'b1;
        bit_d   = bit_q;
        shift_d = shift_q;
        unique case (state_q)
            TS_IDLE: begin
                cnt_d = '0;
                if (start) begin
                    shift_d = data;
                    bit_d   = '0;
                    state_d = TS_START;
                end
            end
            TS_START: if (bit_end) state_d = TS_DATA;
            TS_DATA: if (bit_end) begin
                shift_d = {1'b0, shift_q[7:1]};
                bit_d   = bit_q + 1'b1;
                if (bit_q == 3'd7) state_d = TS_STOP;
            end
            TS_STOP: if (bit_end) state_d = TS_IDLE;
            default: state_d = TS_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q != TS_IDLE);
        unique case (state_q)
            TS_START: tx = 1'b0;
            TS_DATA:  tx = shift_q[0];
            default:  tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbg_msg_fmt.sv
module dbg_msg_fmt
    import dbg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fetch,
    input  logic              req_wback,
    input  logic              req_exec,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [DATA_W-1:0] exec_val,
    input  logic              tx_busy,
    output logic              tx_start,
    output logic [7:0]        tx_byte,
    output logic              busy
);
    localparam int DIGITS = DATA_W / 4;
    localparam int DIG_W  = $clog2(DIGITS + 1);

    fmt_state_e        state_q, state_d;
    logic [DATA_W-1:0] word_a_q, word_a_d, word_b_q, word_b_d;
    logic [1:0]        nfld_q, nfld_d, fld_q, fld_d;
    logic [DIG_W-1:0]  dig_q, dig_d;
    logic [DATA_W-1:0] sel_word, shifted;
    logic              any_req;

    assign any_req = req_fetch | req_wback | req_exec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FS_IDLE;
            word_a_q <= '0;
            word_b_q <= '0;
            nfld_q   <= '0;
            fld_q    <= '0;
            dig_q    <= '0;
        end else begin
            state_q  <= state_d;
            word_a_q <= word_a_d;
            word_b_q <= word_b_d;
            nfld_q   <= nfld_d;
            fld_q    <= fld_d;
            dig_q    <= dig_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        word_a_d = word_a_q;
        word_b_d = word_b_q;
        nfld_d   = nfld_q;
        fld_d    = fld_q;
        dig_d    = dig_q;
        unique case (state_q)
            FS_IDLE: if (any_req) begin
                fld_d   = '0;
                dig_d   = '0;
                state_d = FS_LOAD;
                if (req_fetch) begin
                    word_a_d = pc;
                    word_b_d = instr;
                    nfld_d   = 2'd2;
                end else if (req_wback) begin
                    word_a_d = wb_addr;
                    word_b_d = wb_data;
                    nfld_d   = 2'd2;
                end else begin
                    word_a_d = exec_val;
                    word_b_d = '0;
                    nfld_d   = 2'd1;
                end
            end
            FS_LOAD: state_d = FS_WAIT;
            FS_WAIT: if (!tx_busy) begin
                if (fld_q == nfld_q) begin
                    state_d = FS_IDLE;
                end else if (dig_q == DIG_W'(DIGITS)) begin
                    fld_d   = fld_q + 1'b1;
                    dig_d   = '0;
                    state_d = FS_LOAD;
                end else begin
                    dig_d   = dig_q + 1'b1;
                    state_d = FS_LOAD;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    assign sel_word = (fld_q == 2'd0) ? word_a_q : word_b_q;
    assign shifted  = sel_word << {dig_q, 2'b00};

    always_comb begin
        busy     = (state_q != FS_IDLE);
        tx_start = (state_q == FS_LOAD);
        if (fld_q == nfld_q)
            tx_byte = CH_LF;
        else if (dig_q == DIG_W'(DIGITS))
            tx_byte = (fld_q == nfld_q - 2'd1) ? CH_CR : CH_SPACE;
        else
            tx_byte = hex_char(shifted[DATA_W-1 -: 4]);
    end
endmodule

// File: rtl/dbg_step_ctrl.sv
module dbg_step_ctrl
    import dbg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RADDR_W   = 5,
    parameter int CLK_HZ    = 100_000_000,
    parameter int BAUD      = 115_200,
    parameter int DB_CYCLES = 100_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_mode,
    input  logic               btn_step,
    input  logic               btn_fetch,
    input  logic               btn_wback,
    input  logic               btn_exec,
    input  logic [DATA_W-1:0]  core_pc,
    input  logic [DATA_W-1:0]  core_instr,
    input  logic [RADDR_W-1:0] wb_rd_addr,
    input  logic [DATA_W-1:0]  wb_rd_data,
    input  logic [DATA_W-1:0]  ex_result,
    output logic               core_ce,
    output logic               uart_tx
);
    localparam int NBTN = 5;

    logic [NBTN-1:0] raw_btn, press;
    logic            press_mode, press_step;
    logic            run_mode, fmt_busy, tx_busy, tx_start;
    logic [7:0]      tx_byte;
    mode_state_e     mode_q, mode_d;

    assign raw_btn = {btn_exec, btn_wback, btn_fetch, btn_step, btn_mode};

    for (genvar i = 0; i < NBTN; i++) begin : g_btn
        dbg_btn_cond #(.DB_CYCLES(DB_CYCLES)) i_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_btn[i]),
            .press (press[i])
        );
    end

    assign press_mode = press[0];
    assign press_step = press[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MS_HALT;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MS_HALT:  if (press_mode) mode_d = MS_RUN;
                      else if (press_step) mode_d = MS_PULSE;
            MS_PULSE: mode_d = MS_HALT;
            MS_RUN:   if (press_mode) mode_d = MS_HALT;
            default:  mode_d = MS_HALT;
        endcase
    end

    always_comb begin
        run_mode = (mode_q == MS_RUN);
        core_ce  = (mode_q == MS_RUN) || (mode_q == MS_PULSE);
    end

    dbg_msg_fmt #(.DATA_W(DATA_W)) i_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fetch (press[2]),
        .req_wback (press[3]),
        .req_exec  (press[4]),
        .pc        (core_pc),
        .instr     (core_instr),
        .wb_addr   ({{(DATA_W-RADDR_W){1'b0}}, wb_rd_addr}),
        .wb_data   (wb_rd_data),
        .exec_val  (ex_result),
        .tx_busy   (tx_busy),
        .tx_start  (tx_start),
        .tx_byte   (tx_byte),
        .busy      (fmt_busy)
    );

    dbg_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .data  (tx_byte),
        .busy  (tx_busy),
        .tx    (uart_tx)
    );
endmodule

// File: rtl/dbg_step_ctrl_chk.sv
module dbg_step_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic core_ce,
    input logic uart_tx,
    input logic run_mode,
    input logic fmt_busy,
    input logic press_mode,
    input logic press_step
);
    always @(negedge clk) begin
        if (rst_n === 1'b0)
            AST_RESET_QUIET: assert (core_ce === 1'b0 && uart_tx === 1'b1); // R1
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ce && !run_mode) |=> !core_ce); // R4

    AST_CE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_ce) |-> $past(press_mode || press_step)); // R3

    AST_START_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uart_tx) |-> fmt_busy); // R8

    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_busy |-> uart_tx); // R8
endmodule

bind dbg_step_ctrl dbg_step_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ce    (core_ce),
    .uart_tx    (uart_tx),
    .run_mode   (run_mode),
    .fmt_busy   (fmt_busy),
    .press_mode (press_mode),
    .press_step (press_step)
);

// File: tb/test_dbg_step_ctrl.sv
module test_dbg_step_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_152_000;
    localparam int BAUD       = 115_200;
    localparam int DIV        = CLK_HZ / BAUD;
    localparam int DB         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  btn = '0;
    logic [31:0] pc = '0, instr = '0, wb_data = '0, exres = '0;
    logic [4:0]  wb_addr = '0;
    logic        core_ce, uart_tx;

    int compared = 0, mismatched = 0, cyc = 0;
    int toggle_at = -1, step_at = -1;
    bit run_m = 0;
    string tag = "R1";
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbg_step_ctrl #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DB_CYCLES(DB)) i_dbg_step_ctrl (
        .clk(clk), .rst_n(rst_n),
        .btn_mode(btn[0]), .btn_step(btn[1]), .btn_fetch(btn[2]),
        .btn_wback(btn[3]), .btn_exec(btn[4]),
        .core_pc(pc), .core_instr(instr), .wb_rd_addr(wb_addr),
        .wb_rd_data(wb_data), .ex_result(exres),
        .core_ce(core_ce), .uart_tx(uart_tx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model for the clock enable (R3, R4)
    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc == toggle_at) run_m = !run_m;
            check("R3/R4 core_ce", {31'b0, core_ce},
                  {31'b0, run_m || (cyc == step_at && !run_m)});
        end
    end

    // Serial receiver (R8) compared against the expected text queue
    initial begin
        logic [7:0] ch;
        forever begin
            @(negedge clk);
            if (rst_n && uart_tx === 1'b0) begin
                repeat (DIV/2) @(negedge clk);
                check("R8 start bit", {31'b0, uart_tx}, 32'd0);
                for (int b = 0; b < 8; b++) begin
                    repeat (DIV) @(negedge clk);
                    ch[b] = uart_tx;
                end
                repeat (DIV) @(negedge clk);
                check("R8 stop bit", {31'b0, uart_tx}, 32'd1);
                if (exp_q.size() == 0) begin
                    check({tag, " unexpected char"}, {24'b0, ch}, 32'hFFFF_FFFF);
                end else begin
                    check({tag, " char"}, {24'b0, ch}, {24'b0, exp_q.pop_front()});
                end
            end
        end
    end

    function automatic logic [7:0] hx(input logic [3:0] n);
        return (n < 10) ? 8'(8'h30 + n) : 8'(8'h41 + n - 10);
    endfunction

    task automatic push_word(input logic [31:0] w);
        for (int i = 7; i >= 0; i--) exp_q.push_back(hx(w[i*4 +: 4]));
    endtask

    task automatic push_line(input logic [31:0] a, input logic [31:0] b, input bit two);
        push_word(a);
        if (two) begin
            exp_q.push_back(8'h20);
            push_word(b);
        end
        exp_q.push_back(8'h0D);
        exp_q.push_back(8'h0A);
    endtask

    // Drive a clean press; mask bits: 0 mode, 1 step, 2 fetch, 3 wback, 4 exec
    task automatic press(input logic [4:0] mask);
        @(negedge clk);
        btn = mask;
        if (mask[0]) toggle_at = cyc + DB + 3;
        if (mask[1]) step_at   = cyc + DB + 3;
        repeat (DB + 6) @(negedge clk);
        btn = '0;
        repeat (DB + 6) @(negedge clk);
    endtask

    task automatic glitch(input logic [4:0] mask);
        @(negedge clk);
        btn = mask;
        repeat (DB - 1) @(negedge clk);
        btn = '0;
        repeat (DB + 6) @(negedge clk);
    endtask

    task automatic wait_line;
        wait (exp_q.size() == 0);
        repeat (3 * DIV) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ce in reset", {31'b0, core_ce}, 32'd0);
        check("R1 tx in reset", {31'b0, uart_tx}, 32'd1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ce after reset", {31'b0, core_ce}, 32'd0);
        check("R1 tx after reset", {31'b0, uart_tx}, 32'd1);

        tag = "R4"; press(5'b00010);                  // single step
        tag = "R2"; glitch(5'b00010);                 // too short: no pulse
        tag = "R3"; press(5'b00001);                  // to run
        tag = "R4"; press(5'b00010);                  // step ignored in run
        tag = "R3"; press(5'b00001);                  // back to halt
        tag = "R4"; press(5'b00010);

        tag = "R5";
        pc = 32'h0000_1A3C; instr = 32'hFEDC_BA98;
        push_line(pc, instr, 1); press(5'b00100); wait_line();

        tag = "R6";
        wb_addr = 5'h1F; wb_data = 32'h0123_4567;
        push_line({27'b0, wb_addr}, wb_data, 1); press(5'b01000); wait_line();

        tag = "R7";
        exres = 32'h8000_00FF;
        push_line(exres, 32'h0, 0); press(5'b10000); wait_line();

        tag = "R10";
        pc = 32'hDEAD_BEEF; instr = 32'h0000_0013;
        push_line(pc, instr, 1);
        fork press(5'b00100); join_none
        @(negedge uart_tx);
        pc = 32'h1111_1111; instr = 32'h2222_2222;
        wait_line();

        tag = "R9";
        exres = 32'h5555_AAAA;
        push_line(pc, instr, 1);
        fork press(5'b00100); join_none
        @(negedge uart_tx);
        press(5'b10000);                              // dropped while busy
        wait_line();

        tag = "R11";
        push_line(pc, instr, 1); press(5'b11100); wait_line();

        tag = "R2"; glitch(5'b00100); repeat (20 * DIV) @(negedge clk);
        check("R2 no text from glitch", exp_q.size(), 0);
        check("R3 final halt ce", {31'b0, core_ce}, 32'd0);
        finish_run();
    end
endmodule